// File: doc/BRIEF.md
# SPI Master with Per-Word Chip-Select Routing

This block is an SPI master (clock mode 0, MSB first) that drives four active-low peripheral select lines. Software sees three write-only locations: a mode word, a control word and a transmit word. The select target for a transfer comes either from a field of the mode word, or from a 4-bit code carried inside each transmit word. With per-word routing, consecutive words can reach different peripherals without the mode word being rewritten.

A keep-select option holds the active select low between words so that a multi-word frame stays framed on one peripheral. The select is released when a word flagged as the final one has been shifted out, or when software disables the block. When a held select must move to another peripheral, every line stays high for at least one full SCK period before the new line goes low. A single receive holding register captures the bits shifted in on MISO. A flag tells software when the holding register and the shifter have both drained.

Top module: `spi_cs_master`

## Requirements
- R1: The lines ncs[3:0] are active low and at most one of them is low at any time. After reset all four are high, sck is low and txempty is high.
- R2: The 4-bit select code is decoded by its lowest zero bit. xxx0 selects line 0, xx01 selects line 1, x011 selects line 2, 0111 selects line 3. 1111 selects no line, but the word is still shifted out.
- R3: With mode bit 0 clear (fixed routing), the target is the code in mode bits 7:4, and the code inside a transmit word has no effect.
- R4: With mode bit 0 set (per-word routing), the code in transmit-word bits 19:16 chooses the target for that word alone.
- R5: The transmit word holds data in bits 15:0 and the final-word flag in bit 24. The word length is 8 plus mode bits 11:8, capped at 16. Only the low bits of the data, up to that length, are sent, most significant first.
- R6: SCK idles low. MOSI is valid before each rising edge, and MISO is sampled on the rising edge. Each SCK half period lasts mode bits 23:16 system cycles (0 acts as 1). At the end of a word, rx_data holds the received bits and rx_valid pulses for one cycle.
- R7: With mode bit 1 (keep-select) set, the select stays low after a word and stays low for a following word to the same target. With it clear, the select is released after every word.
- R8: A word with the final-word flag set releases the select after it is shifted out, even when keep-select is on.
- R9: When a select is released, all lines stay high for at least two half periods of the word just sent before any line goes low again. This includes a held select being moved to another target.
- R10: Writing control bit 1 (disable) lets a word already shifting finish, and then releases any held select. It leaves the mode word unchanged. Writing control bit 0 (enable) allows transfers again. If both bits are written together, disable wins.
- R11: txempty is high only when the transmit holding register is empty and the engine is idle. It is low while shifting, during the trailing hold and during the release gap.
- R12: A transmit write is accepted only when the block is enabled and the holding register is empty. Any other transmit write is dropped and produces no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 control, 2 transmit |
| wr_data | input | 32 | Register write data |
| txempty | output | 1 | Holding register and shifter both drained |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data to the peripherals |
| miso | input | 1 | Serial data from the peripherals |
| ncs | output | 4 | Active-low peripheral selects |
| rx_data | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |

## Verification
The bench goes after the routing corner cases. It walks all five decode classes, including the no-select code, and sends a fixed-mode word whose own code points elsewhere. A decoder keyed on the wrong bit, or a fixed mode that obeys the word's code, would put bits on the wrong line. It then moves a held select to a new target and measures the high gap. It also sends same-target words under keep-select and counts the releases. A design that switches lines directly, or that releases needlessly, shows up in the gap length or the release count. Disable is issued both mid-word and while a select is held, and back-to-back transmit writes are aimed at a full holding register. A design that truncates the word, keeps the select low, or accepts the dropped writes would emit a wrong or an extra word.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    localparam int NUM_CS   = 4;
    localparam int PCS_W    = 4;
    localparam int DATA_W   = 16;
    localparam int MIN_BITS = 8;
    localparam int DIV_W    = 8;
    localparam int WCODE_W  = 4;
    localparam int CNT_W    = DIV_W + 1;
    localparam int BIT_W    = $clog2(DATA_W + 1);
    localparam int BUS_W    = 32;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_TX   = 2'd2;

    localparam int MODE_VSEL_BIT  = 0;
    localparam int MODE_KEEP_BIT  = 1;
    localparam int MODE_PCS_LSB   = 4;
    localparam int MODE_WIDTH_LSB = 8;
    localparam int MODE_DIV_LSB   = 16;
    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_DIS_BIT   = 1;
    localparam int TX_PCS_LSB     = 16;
    localparam int TX_LAST_BIT    = 24;

    typedef struct packed {
        logic               vsel;
        logic               keep;
        logic [PCS_W-1:0]   pcs;
        logic [WCODE_W-1:0] wcode;
        logic [DIV_W-1:0]   half;
    } mode_t;

    typedef struct packed {
        logic              last;
        logic [PCS_W-1:0]  pcs;
        logic [DATA_W-1:0] data;
    } word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_TRAIL,
        ST_GAP
    } eng_st_e;

    function automatic logic [BIT_W-1:0] word_bits(input logic [WCODE_W-1:0] code);
        int n;
        n = MIN_BITS + int'(code);
        if (n > DATA_W) n = DATA_W;
        return BIT_W'(n);
    endfunction

    function automatic logic [DIV_W-1:0] half_eff(input logic [DIV_W-1:0] h);
        return (h == '0) ? DIV_W'(1) : h;
    endfunction

endpackage

// File: rtl/spi_cs_regs.sv
module spi_cs_regs
    import spi_cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             take,
    output mode_t            mode,
    output logic             enabled,
    output logic             thr_valid,
    output word_t            thr
);

    typedef struct packed {
        mode_t mode;
        logic  en;
        logic  tv;
        word_t thr;
    } regs_t;

    regs_t d, q;

    logic unused_bits;
    assign unused_bits = ^{wr_data[31:25], wr_data[23:20]};

    always_comb begin
        d = q;
        if (take) d.tv = 1'b0;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_MODE: begin
                    d.mode.vsel  = wr_data[MODE_VSEL_BIT];
                    d.mode.keep  = wr_data[MODE_KEEP_BIT];
                    d.mode.pcs   = wr_data[MODE_PCS_LSB +: PCS_W];
                    d.mode.wcode = wr_data[MODE_WIDTH_LSB +: WCODE_W];
                    d.mode.half  = wr_data[MODE_DIV_LSB +: DIV_W];
                end
                ADDR_CTRL: begin
                    if (wr_data[CTRL_DIS_BIT])      d.en = 1'b0;
                    else if (wr_data[CTRL_EN_BIT])  d.en = 1'b1;
                end
                ADDR_TX: begin
                    if (q.en && !q.tv) begin
                        d.tv       = 1'b1;
                        d.thr.last = wr_data[TX_LAST_BIT];
                        d.thr.pcs  = wr_data[TX_PCS_LSB +: PCS_W];
                        d.thr.data = wr_data[DATA_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.mode.half  <= DIV_W'(1);
        end else begin
            q <= d;
        end
    end

    assign mode      = q.mode;
    assign enabled   = q.en;
    assign thr_valid = q.tv;
    assign thr       = q.thr;

endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
    parameter int N_SEL  = 4,
    parameter int CODE_W = 4
) (
    input  logic              cs_on,
    input  logic [CODE_W-1:0] code,
    output logic [N_SEL-1:0]  ncs
);

    for (genvar i = 0; i < N_SEL; i++) begin : g_sel
        localparam logic [CODE_W-1:0] BELOW = CODE_W'((1 << i) - 1);
        logic ones_below;
        assign ones_below = &(code | ~BELOW);
        assign ncs[i]     = ~(cs_on & ~code[i] & ones_below);
    end

endmodule

// File: rtl/spi_cs_engine.sv
module spi_cs_engine
    import spi_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enabled,
    input  mode_t             mode,
    input  logic              thr_valid,
    input  word_t             thr,
    input  logic              miso,
    output logic              take,
    output logic              sck,
    output logic              mosi,
    output logic              cs_on,
    output logic [PCS_W-1:0]  cs_code,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              idle,
    output logic [DIV_W-1:0]  half_act
);

    typedef struct packed {
        eng_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bit_idx;
        logic [BIT_W-1:0]  nbits;
        logic [DIV_W-1:0]  half;
        logic              sck;
        logic [DATA_W-1:0] sreg;
        logic [DATA_W-1:0] rsreg;
        logic              cs_on;
        logic [PCS_W-1:0]  cs_code;
        logic              last;
        logic [DATA_W-1:0] rx_data;
        logic              rx_valid;
    } eng_t;

    eng_t d, q;

    logic [PCS_W-1:0] tgt;
    logic [BIT_W-1:0] nb_new;
    logic [BIT_W-1:0] shamt;
    logic [CNT_W-1:0] half_end;
    logic [CNT_W-1:0] gap_end;
    logic             start;

    always_comb begin
        d          = q;
        take       = 1'b0;
        start      = 1'b0;
        d.rx_valid = 1'b0;
        tgt        = mode.vsel ? thr.pcs : mode.pcs;
        nb_new     = word_bits(mode.wcode);
        shamt      = BIT_W'(DATA_W) - nb_new;
        half_end   = {1'b0, q.half} - CNT_W'(1);
        gap_end    = {q.half, 1'b0} - CNT_W'(1);

        unique case (q.st)
            ST_IDLE: begin
                if (q.cs_on) begin
                    if (!enabled) begin
                        d.cs_on = 1'b0;
                        d.st    = ST_GAP;
                        d.cnt   = '0;
                    end else if (thr_valid) begin
                        if (tgt == q.cs_code) begin
                            start = 1'b1;
                        end else begin
                            d.cs_on = 1'b0;
                            d.st    = ST_GAP;
                            d.cnt   = '0;
                        end
                    end
                end else if (enabled && thr_valid) begin
                    start = 1'b1;
                end
                if (start) begin
                    take      = 1'b1;
                    d.st      = ST_SHIFT;
                    d.cs_on   = 1'b1;
                    d.cs_code = tgt;
                    d.nbits   = nb_new;
                    d.half    = half_eff(mode.half);
                    d.sreg    = thr.data << shamt;
                    d.rsreg   = '0;
                    d.last    = thr.last;
                    d.cnt     = '0;
                    d.bit_idx = '0;
                    d.sck     = 1'b0;
                end
            end
            ST_SHIFT: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt == half_end) begin
                    d.cnt = '0;
                    if (!q.sck) begin
                        d.sck   = 1'b1;
                        d.rsreg = {q.rsreg[DATA_W-2:0], miso};
                    end else begin
                        d.sck = 1'b0;
                        if (q.bit_idx == q.nbits - BIT_W'(1)) begin
                            d.st       = ST_TRAIL;
                            d.rx_data  = q.rsreg;
                            d.rx_valid = 1'b1;
                        end else begin
                            d.bit_idx = q.bit_idx + BIT_W'(1);
                            d.sreg    = {q.sreg[DATA_W-2:0], 1'b0};
                        end
                    end
                end
            end
            ST_TRAIL: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt == half_end) begin
                    d.cnt = '0;
                    if (q.last || !mode.keep || !enabled) begin
                        d.cs_on = 1'b0;
                        d.st    = ST_GAP;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt == gap_end) begin
                    d.cnt = '0;
                    d.st  = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.half <= DIV_W'(1);
        end else begin
            q <= d;
        end
    end

    assign sck      = q.sck;
    assign mosi     = (q.st == ST_SHIFT) ? q.sreg[DATA_W-1] : 1'b0;
    assign cs_on    = q.cs_on;
    assign cs_code  = q.cs_code;
    assign rx_data  = q.rx_data;
    assign rx_valid = q.rx_valid;
    assign idle     = (q.st == ST_IDLE);
    assign half_act = q.half;

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
    import spi_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic              txempty,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] ncs,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    mode_t             mode_w;
    word_t             thr_w;
    logic              en_w;
    logic              tv_w;
    logic              take_w;
    logic              cs_on_w;
    logic [PCS_W-1:0]  cs_code_w;
    logic              idle_w;
    logic [DIV_W-1:0]  act_half;

    spi_cs_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .take      (take_w),
        .mode      (mode_w),
        .enabled   (en_w),
        .thr_valid (tv_w),
        .thr       (thr_w)
    );

    spi_cs_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .enabled   (en_w),
        .mode      (mode_w),
        .thr_valid (tv_w),
        .thr       (thr_w),
        .miso      (miso),
        .take      (take_w),
        .sck       (sck),
        .mosi      (mosi),
        .cs_on     (cs_on_w),
        .cs_code   (cs_code_w),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .idle      (idle_w),
        .half_act  (act_half)
    );

    spi_cs_decode #(
        .N_SEL  (NUM_CS),
        .CODE_W (PCS_W)
    ) u_dec (
        .cs_on (cs_on_w),
        .code  (cs_code_w),
        .ncs   (ncs)
    );

    assign txempty = !tv_w && idle_w;

endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk
    import spi_cs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] ncs,
    input logic              sck,
    input logic              txempty,
    input logic              rx_valid,
    input logic [DIV_W-1:0]  act_half
);

    localparam int HC_W = DIV_W + 2;

    logic [HC_W-1:0] hi_cnt_q;
    logic            was_high_q;
    logic            all_high;

    assign all_high = (ncs == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q   <= '1;
            was_high_q <= 1'b1;
        end else begin
            was_high_q <= all_high;
            if (!all_high)            hi_cnt_q <= '0;
            else if (hi_cnt_q != '1)  hi_cnt_q <= hi_cnt_q + HC_W'(1);
        end
    end

    assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ncs));

    assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        txempty |-> !sck);

    assert_cs_stable_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sck) || $fell(sck)) |-> $stable(ncs));

    assert_release_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (was_high_q && !all_high) |-> (hi_cnt_q >= HC_W'({act_half, 1'b0})));

    assert_busy_at_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !txempty);

endmodule

bind spi_cs_master spi_cs_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ncs      (ncs),
    .sck      (sck),
    .txempty  (txempty),
    .rx_valid (rx_valid),
    .act_half (act_half)
);

// File: tb/spi_cs_master_tb.sv
module spi_cs_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        txempty, sck, mosi, miso, rx_valid;
    logic [3:0]  ncs;
    logic [15:0] rx_data;

    always #2 clk = ~clk;

    assign miso = ~mosi;

    spi_cs_master u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .txempty(txempty), .sck(sck), .mosi(mosi),
        .miso(miso), .ncs(ncs), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    typedef struct {
        int          idx;
        logic [15:0] data;
        int          nb;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cur_half = 1;
    int   releases = 0;
    int   last_gap = 0;
    int   hi_run = 1000;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic int cs_idx(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (!v[i]) return i;
        return 4;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] dv);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = dv;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input bit vsel, input bit keep, input logic [3:0] fpcs,
                            input logic [3:0] wcode, input int half);
        cur_half = (half == 0) ? 1 : half;
        wr(2'd0, {8'h0, 8'(half), 4'h0, wcode, fpcs, 2'b0, keep, vsel});
    endtask

    function automatic logic [31:0] txw(input logic [3:0] pcs, input logic [15:0] dv, input bit last);
        return {7'b0, last, 4'b0, pcs, dv};
    endfunction

    task automatic send(input logic [3:0] pcs, input logic [15:0] dv, input bit last,
                        input int idx, input int nb);
        exp_t e;
        e.idx = idx; e.data = dv; e.nb = nb;
        exp_q.push_back(e);
        wr(2'd2, txw(pcs, dv, last));
    endtask

    task automatic wait_empty();
        @(negedge clk);
        while (!txempty) @(negedge clk);
    endtask

    // monitor: scoreboard comparison of serial words, routing and received data
    initial begin : monitor
        logic        prev_sck = 1'b0;
        int          bitc = 0;
        int          hc = 0;
        logic [15:0] got = '0;
        exp_t        cur;
        bit          active = 1'b0;
        bit          wait_rx = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (sck && !prev_sck) begin
                    if (!active) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R12 unexpected word", 1, 0);
                            cur.idx = 4; cur.data = '0; cur.nb = 8;
                        end else begin
                            cur = exp_q.pop_front();
                        end
                        active = 1'b1; bitc = 0; got = '0;
                        check(cs_idx(ncs) == cur.idx, "R2/R3/R4 target line",
                              cs_idx(ncs), cur.idx);
                    end
                    got = {got[14:0], mosi};
                    bitc++;
                end
                if (sck) hc++;
                if (!sck && prev_sck) begin
                    check(hc == cur_half, "R6 half period", hc, cur_half);
                    hc = 0;
                    if (active && bitc == cur.nb) begin
                        logic [15:0] m;
                        m = 16'((17'h1 << cur.nb) - 17'h1);
                        check(got == (cur.data & m), "R5 serial data", got, cur.data & m);
                        active = 1'b0;
                        wait_rx = 1'b1;
                    end
                end
                if (rx_valid) begin
                    logic [15:0] m2;
                    m2 = 16'((17'h1 << cur.nb) - 17'h1);
                    check(wait_rx && rx_data == (~cur.data & m2), "R6 rx holding",
                          rx_data, ~cur.data & m2);
                    wait_rx = 1'b0;
                end
                prev_sck = sck;
            end
        end
    end

    // gap and release tracker
    initial begin : gaps
        logic [3:0] prev = 4'hF;
        forever begin
            @(negedge clk);
            if (ncs == 4'hF) begin
                hi_run++;
                if (prev != 4'hF) releases++;
            end else begin
                if (prev == 4'hF) last_gap = hi_run;
                hi_run = 0;
            end
            prev = ncs;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        int rel0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ncs == 4'hF, "R1 reset ncs", ncs, 4'hF);
        check(txempty == 1'b1, "R1 reset txempty", txempty, 1);
        check(sck == 1'b0, "R1 reset sck", sck, 0);

        wr(2'd1, 32'h1);

        // R3: fixed routing to line 1, word code points at line 0
        set_mode(1'b0, 1'b0, 4'b0001, 4'd0, 2);
        send(4'b0000, 16'h00A5, 1'b0, 1, 8);
        wait_empty();
        check(ncs == 4'hF, "R7 released without keep", ncs, 4'hF);

        // R2 R4 R5: per-word routing, 12-bit words, all decode classes
        set_mode(1'b1, 1'b0, 4'b0000, 4'd4, 1);
        send(4'b1010, 16'h0ABC, 1'b0, 0, 12); wait_empty();
        send(4'b0101, 16'h0123, 1'b0, 1, 12); wait_empty();
        send(4'b1011, 16'h0F0F, 1'b0, 2, 12); wait_empty();
        send(4'b0111, 16'h0C3A, 1'b0, 3, 12); wait_empty();
        send(4'b1111, 16'h0555, 1'b0, 4, 12); wait_empty();

        // R5 R6: full width, and a width code past the cap
        set_mode(1'b1, 1'b0, 4'b0000, 4'd8, 3);
        send(4'b0000, 16'hBEEF, 1'b0, 0, 16); wait_empty();
        set_mode(1'b1, 1'b0, 4'b0000, 4'd15, 0);
        send(4'b0001, 16'h8421, 1'b0, 1, 16); wait_empty();

        // R7 R8 R9: keep-select, target change, final-word release
        set_mode(1'b1, 1'b1, 4'b0000, 4'd0, 2);
        send(4'b0000, 16'h005A, 1'b0, 0, 8); wait_empty();
        check(ncs == 4'b1110, "R7 held after word", ncs, 4'b1110);
        send(4'b0011, 16'h00C3, 1'b0, 2, 8); wait_empty();
        check(last_gap >= 4, "R9 gap before new target", last_gap, 4);
        check(ncs == 4'b1011, "R7 held on new target", ncs, 4'b1011);
        rel0 = releases;
        send(4'b0011, 16'h0011, 1'b0, 2, 8); wait_empty();
        check(releases == rel0, "R7 no release for same target", releases, rel0);
        send(4'b0011, 16'h0022, 1'b1, 2, 8); wait_empty();
        check(ncs == 4'hF, "R8 final word releases", ncs, 4'hF);

        // R10: disable releases a held select, config kept
        send(4'b0111, 16'h0077, 1'b0, 3, 8); wait_empty();
        check(ncs == 4'b0111, "R7 held line 3", ncs, 4'b0111);
        wr(2'd1, 32'h3);
        repeat (8) @(negedge clk);
        check(ncs == 4'hF, "R10 disable releases", ncs, 4'hF);
        // R12: transmit write while disabled is dropped
        wr(2'd2, txw(4'b0000, 16'h00FF, 1'b0));
        repeat (40) @(negedge clk);
        check(txempty == 1'b1, "R12 dropped while disabled", txempty, 1);
        check(sck == 1'b0 && ncs == 4'hF, "R12 no activity", {sck, ncs}, 5'h0F);
        wr(2'd1, 32'h1);
        send(4'b0101, 16'h0099, 1'b1, 1, 8); wait_empty();

        // R10: disable mid-word, word completes, select released despite keep
        send(4'b0000, 16'h00E7, 1'b0, 0, 8);
        @(negedge clk);
        while (!sck) @(negedge clk);
        wr(2'd1, 32'h2);
        wait_empty();
        repeat (4) @(negedge clk);
        check(ncs == 4'hF, "R10 mid-word disable releases", ncs, 4'hF);
        wr(2'd1, 32'h1);

        // R11 R12: back-to-back writes against a full holding register
        set_mode(1'b1, 1'b0, 4'b0000, 4'd0, 1);
        begin
            exp_t e1, e3;
            e1.idx = 0; e1.data = 16'h0031; e1.nb = 8;
            e3.idx = 1; e3.data = 16'h0033; e3.nb = 8;
            exp_q.push_back(e1);
            exp_q.push_back(e3);
        end
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = txw(4'b0000, 16'h0031, 1'b0);
        @(negedge clk);
        check(txempty == 1'b0, "R11 not empty after write", txempty, 0);
        wr_data = txw(4'b0000, 16'h0032, 1'b0);
        @(negedge clk);
        wr_data = txw(4'b0001, 16'h0033, 1'b0);
        @(negedge clk);
        wr_data = txw(4'b0010, 16'h0034, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        check(txempty == 1'b0, "R11 busy while shifting", txempty, 0);
        wait_empty();
        wait_empty();
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R12 all expected words seen", exp_q.size(), 0);
        check(txempty == 1'b1 && ncs == 4'hF, "R11 idle at end", {txempty, ncs}, 5'h1F);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule